// File: doc/BRIEF.md
# 64-bit ARX Mixing Round

This block scrambles four 64-bit state words with a fixed sequence of eight add-rotate-XOR operations. The additions are hardened: besides the plain sum, each adds twice the product of the two operands' low 32-bit halves. The rotations are circular, and every sum wraps modulo 2^64. Every step reads the values that the steps before it wrote, so the sequence is strictly ordered.

The four words are presented together with a single-cycle `in_valid`. The block then performs one step per clock cycle, so one 32×32 multiplier serves all four additions. After the eighth step it raises `out_valid` for one cycle, with the mixed words on the outputs.

The data interfaces have no back-pressure. The block has no ready signal. `in_valid` is taken only while the block is idle and is dropped while a run is in progress. A caller that needs every word set processed must space its requests at least nine cycles apart, or watch `out_valid` before sending the next set.

Top module: `arx_mix_round`

## Requirements
- R1: After reset, `out_valid` is 0 and all four outputs are zero until the first accepted `in_valid`.
- R2: `in_valid` high at a rising edge while idle captures `a_in`..`d_in`. `out_valid` is then high for exactly one cycle, starting just after the eighth rising edge that follows the accepting edge.
- R3: Steps 1, 3, 5 and 7 are the hardened addition x + y + 2·x[31:0]·y[31:0] modulo 2^64.
  - Steps 1 and 5 set a from (a, b).
  - Steps 3 and 7 set c from (c, d).
- R4: Steps 2, 4, 6 and 8 are a circular right rotation of a bitwise XOR:
  - step 2: d ← ror(d^a, 32)
  - step 4: b ← ror(b^c, 24)
  - step 6: d ← ror(d^a, 16)
  - step 8: b ← ror(b^c, 63)
- R5: The steps apply in the order 1 to 8, and each step uses the words updated by the earlier steps. While `out_valid` is high, `a_out`..`d_out` carry the result of all eight steps.
- R6: `in_valid` is ignored at the eight stepping edges of a run. It changes neither the result nor the timing of that run. It is accepted again at the edge that ends the `out_valid` cycle, so a new run can start every nine cycles.
- R7: After `out_valid`, the outputs hold the final words until the next accepted `in_valid`.
- R8: An all-zero input gives an all-zero result. An all-ones input gives the wrapped modulo-2^64 result, with carries above bit 63 discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request to start a run with the words below |
| a_in | input | 64 | Initial word a |
| b_in | input | 64 | Initial word b |
| c_in | input | 64 | Initial word c |
| d_in | input | 64 | Initial word d |
| out_valid | output | 1 | One-cycle pulse marking the final words |
| a_out | output | 64 | Word a |
| b_out | output | 64 | Word b |
| c_out | output | 64 | Word c |
| d_out | output | 64 | Word d |

## Verification
An all-zero vector shows that the multiply term and the rotations add nothing when there are no set bits. An all-ones vector exercises the widest carries and the wrap modulo 2^64, which exposes a dropped or mis-sized product doubling. Random vectors with random gaps separate the four rotation amounts and the step order, because any swapped step gives different words. A stream that holds `in_valid` high with data changing on every cycle tells a block that drops busy-time requests from one that restarts or corrupts a run, and it also checks the nine-cycle restart.

// File: rtl/arx_pkg.sv
package arx_pkg;
  // Number of mixing steps in one round; the sequence is fixed.
  localparam int unsigned ARX_STEPS = 8;
  localparam int unsigned ARX_STEP_W = $clog2(ARX_STEPS);

  // Destination word of a step.
  typedef enum logic [1:0] {
    SEL_A = 2'd0,
    SEL_B = 2'd1,
    SEL_C = 2'd2,
    SEL_D = 2'd3
  } word_sel_e;
endpackage

// File: rtl/arx_mul_core.sv
// Shared unsigned multiplier of the two low halves.
module arx_mul_core #(
  parameter int unsigned HALF_W = 32
) (
  input  logic [HALF_W-1:0]   x_lo,
  input  logic [HALF_W-1:0]   y_lo,
  output logic [2*HALF_W-1:0] prod
);
  logic [2*HALF_W-1:0] x_ext, y_ext;
  assign x_ext = {{HALF_W{1'b0}}, x_lo};
  assign y_ext = {{HALF_W{1'b0}}, y_lo};
  assign prod  = x_ext * y_ext;
endmodule

// File: rtl/arx_step_unit.sv
// Combinational datapath for one step, chosen by the step index.
module arx_step_unit
  import arx_pkg::*;
#(
  parameter int unsigned WORD_W = 64
) (
  input  logic [WORD_W-1:0]     a_cur,
  input  logic [WORD_W-1:0]     b_cur,
  input  logic [WORD_W-1:0]     c_cur,
  input  logic [WORD_W-1:0]     d_cur,
  input  logic [ARX_STEP_W-1:0] step,
  output word_sel_e             dst,
  output logic [WORD_W-1:0]     nxt
);
  localparam int unsigned HALF_W = WORD_W / 2;
  localparam int unsigned N_ROT  = ARX_STEPS / 2;
  // Rotation amounts of the four XOR steps, in step order.
  localparam int unsigned ROT_TAB [N_ROT] = '{
    WORD_W / 2, (3 * WORD_W) / 8, WORD_W / 4, WORD_W - 1
  };

  // Adder operands: steps 1/5 use (a,b), steps 3/7 use (c,d).
  logic              pair_cd;
  logic [WORD_W-1:0] add_x, add_y, prod, sum;
  assign pair_cd = step[1];
  assign add_x   = pair_cd ? c_cur : a_cur;
  assign add_y   = pair_cd ? d_cur : b_cur;

  arx_mul_core #(.HALF_W(HALF_W)) u_mul (
    .x_lo (add_x[HALF_W-1:0]),
    .y_lo (add_y[HALF_W-1:0]),
    .prod (prod)
  );

  assign sum = add_x + add_y + {prod[WORD_W-2:0], 1'b0};

  // XOR operands: steps 2/6 use d^a, steps 4/8 use b^c.
  logic [WORD_W-1:0] mix_x;
  logic [WORD_W-1:0] rot_res [N_ROT];
  assign mix_x = pair_cd ? (b_cur ^ c_cur) : (d_cur ^ a_cur);

  for (genvar g = 0; g < N_ROT; g++) begin : g_rot
    localparam int unsigned R = ROT_TAB[g];
    assign rot_res[g] = {mix_x[R-1:0], mix_x[WORD_W-1:R]};
  end

  logic [ARX_STEP_W-2:0] rot_idx;
  assign rot_idx = step[ARX_STEP_W-1:1];

  always_comb begin
    if (step[0]) begin
      nxt = rot_res[rot_idx];
      dst = pair_cd ? SEL_B : SEL_D;
    end else begin
      nxt = sum;
      dst = pair_cd ? SEL_C : SEL_A;
    end
  end
endmodule

// File: rtl/arx_seq_ctrl.sv
// Step sequencer: idle/busy, step counter and completion pulse.
module arx_seq_ctrl
  import arx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  accept,
  output logic                  busy,
  output logic [ARX_STEP_W-1:0] step,
  output logic                  done
);
  localparam logic [ARX_STEP_W-1:0] LAST = ARX_STEP_W'(ARX_STEPS - 1);

  logic                  busy_q, done_q;
  logic [ARX_STEP_W-1:0] step_q;
  logic                  last_step;

  assign accept    = in_valid & ~busy_q;
  assign last_step = busy_q && (step_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_step;
      if (accept) begin
        busy_q <= 1'b1;
        step_q <= '0;
      end else if (busy_q) begin
        step_q <= step_q + ARX_STEP_W'(1);
        if (last_step) busy_q <= 1'b0;
      end
    end
  end

  assign busy = busy_q;
  assign step = step_q;
  assign done = done_q;

  // R2
  ov_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R6
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && in_valid && step_q != LAST) |=>
      (busy_q && step_q == $past(step_q) + ARX_STEP_W'(1)));

  // R2
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && step_q == LAST) |=> (done_q && !busy_q));
endmodule

// File: rtl/arx_mix_round.sv
// Top: state words, load path and per-step write-back.
module arx_mix_round
  import arx_pkg::*;
#(
  parameter int unsigned WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] a_in,
  input  logic [WORD_W-1:0] b_in,
  input  logic [WORD_W-1:0] c_in,
  input  logic [WORD_W-1:0] d_in,
  output logic              out_valid,
  output logic [WORD_W-1:0] a_out,
  output logic [WORD_W-1:0] b_out,
  output logic [WORD_W-1:0] c_out,
  output logic [WORD_W-1:0] d_out
);
  logic                  accept, busy, done;
  logic [ARX_STEP_W-1:0] step;
  word_sel_e             dst;
  logic [WORD_W-1:0]     nxt;
  logic [WORD_W-1:0]     a_q, b_q, c_q, d_q;

  arx_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .accept   (accept),
    .busy     (busy),
    .step     (step),
    .done     (done)
  );

  arx_step_unit #(.WORD_W(WORD_W)) u_step (
    .a_cur (a_q),
    .b_cur (b_q),
    .c_cur (c_q),
    .d_cur (d_q),
    .step  (step),
    .dst   (dst),
    .nxt   (nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
      c_q <= '0;
      d_q <= '0;
    end else if (accept) begin
      a_q <= a_in;
      b_q <= b_in;
      c_q <= c_in;
      d_q <= d_in;
    end else if (busy) begin
      case (dst)
        SEL_A:   a_q <= nxt;
        SEL_B:   b_q <= nxt;
        SEL_C:   c_q <= nxt;
        default: d_q <= nxt;
      endcase
    end
  end

  assign out_valid = done;
  assign a_out = a_q;
  assign b_out = b_q;
  assign c_out = c_q;
  assign d_out = d_q;

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (a_q == $past(a_in) && b_q == $past(b_in) &&
                c_q == $past(c_in) && d_q == $past(d_in)));

  // R4
  rot_d_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step[0] && !step[1]) |=>
      ($countones(d_q) == $countones($past(d_q ^ a_q))));

  // R4
  rot_b_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step[0] && step[1]) |=>
      ($countones(b_q) == $countones($past(b_q ^ c_q))));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !in_valid) |=>
      ($stable(a_q) && $stable(b_q) && $stable(c_q) && $stable(d_q)));

  // R2
  ov_ends_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> ($past(busy) && !busy));
endmodule

// File: tb/arx_mix_round_test.sv
`timescale 1ns/1ps
module arx_mix_round_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] a_in, b_in, c_in, d_in;
  logic        out_valid;
  logic [63:0] a_out, b_out, c_out, d_out;

  always #2 clk = ~clk;

  arx_mix_round uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .a_in(a_in), .b_in(b_in), .c_in(c_in), .d_in(d_in),
    .out_valid(out_valid),
    .a_out(a_out), .b_out(b_out), .c_out(c_out), .d_out(d_out)
  );

  int    checks = 0;
  int    failures = 0;
  bit    finished = 0;
  string out_tag = "R3 R4 R5";
  string ov_tag = "R2";

  // Behavioural reference of the whole round.
  function automatic logic [63:0] hadd(logic [63:0] x, logic [63:0] y);
    logic [63:0] p;
    p = 64'(x[31:0]) * 64'(y[31:0]);
    return x + y + (p << 1);
  endfunction

  function automatic logic [63:0] rotr(logic [63:0] v, int n);
    return (v >> n) | (v << (64 - n));
  endfunction

  function automatic logic [255:0] round_ref(logic [63:0] a, logic [63:0] b,
                                              logic [63:0] c, logic [63:0] d);
    a = hadd(a, b);  d = rotr(d ^ a, 32);
    c = hadd(c, d);  b = rotr(b ^ c, 24);
    a = hadd(a, b);  d = rotr(d ^ a, 16);
    c = hadd(c, d);  b = rotr(b ^ c, 63);
    return {a, b, c, d};
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s got %h exp %h", req, what, act, exp);
    end
  endtask

  // Cycle model: idle/busy, edge count, expected pulse and result.
  bit          m_busy, m_outv, m_hold;
  int          m_cnt;
  logic [255:0] m_exp;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_outv = 0; m_hold = 1; m_cnt = 0; m_exp = '0;
    end else if (!m_busy && in_valid) begin
      m_busy = 1; m_cnt = 0; m_outv = 0; m_hold = 0;
      m_exp = round_ref(a_in, b_in, c_in, d_in);
    end else if (m_busy) begin
      m_cnt++;
      m_outv = (m_cnt == 8);
      if (m_cnt == 8) begin m_busy = 0; m_hold = 1; end
    end else begin
      m_outv = 0;
    end
  end

  bit cmp_en = 0;
  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      chk(ov_tag, "out_valid", 64'(out_valid), 64'(m_outv));
      if (m_outv || m_hold) begin
        string t;
        t = m_outv ? out_tag : "R7";
        chk(t, "a_out", a_out, m_exp[255:192]);
        chk(t, "b_out", b_out, m_exp[191:128]);
        chk(t, "c_out", c_out, m_exp[127:64]);
        chk(t, "d_out", d_out, m_exp[63:0]);
      end
    end
  end

  task automatic send(logic [63:0] a, logic [63:0] b, logic [63:0] c,
                      logic [63:0] d, int gap);
    @(negedge clk);
    in_valid = 1; a_in = a; b_in = b; c_in = c; d_in = d;
    @(negedge clk);
    in_valid = 0;
    repeat (gap) @(negedge clk);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    #(4 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL R2 watchdog got running exp done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; in_valid = 0;
    a_in = '0; b_in = '0; c_in = '0; d_in = '0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "out_valid", 64'(out_valid), 64'd0);
    chk("R1", "a_out", a_out, 64'd0);
    chk("R1", "d_out", d_out, 64'd0);
    cmp_en = 1;

    // R8 corners
    out_tag = "R8";
    send('0, '0, '0, '0, 10);
    send('1, '1, '1, '1, 10);
    out_tag = "R3 R4 R5";
    send(64'h0123_4567_89ab_cdef, 64'hfedc_ba98_7654_3210,
         64'h0000_0001_0000_0001, 64'h8000_0000_0000_0000, 10);

    // R6: requests during a run with different data are ignored
    ov_tag = "R6";
    send(rnd64(), rnd64(), rnd64(), rnd64(), 1);
    for (int i = 0; i < 5; i++) begin
      in_valid = 1; a_in = rnd64(); b_in = rnd64(); c_in = rnd64(); d_in = rnd64();
      @(negedge clk);
    end
    in_valid = 0;
    repeat (10) @(negedge clk);

    // R6: continuous stream, accepted every nine cycles
    for (int i = 0; i < 40; i++) begin
      in_valid = 1; a_in = rnd64(); b_in = rnd64(); c_in = rnd64(); d_in = rnd64();
      @(negedge clk);
    end
    in_valid = 0;
    repeat (10) @(negedge clk);
    ov_tag = "R2";

    // Random vectors with random gaps
    for (int i = 0; i < 150; i++)
      send(rnd64(), rnd64(), rnd64(), rnd64(), 8 + int'($urandom_range(0, 4)));

    repeat (12) @(negedge clk);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule